// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block tracks loads that a compiler has moved above earlier stores. When such a hoisted load issues, it records its destination register number and its memory address in a small associative table. Every store that follows presents its address, and all valid entries compare against it at once. Any entry whose 8-byte word matches the store is marked invalid, because the speculative value it stands for may now be stale.

At the load's original place in the program, a check operation names the register. The table answers one cycle later. A hit means the speculative value may still be used. A miss means the entry was invalidated or is no longer present, and the pipeline must branch to recovery code.

Entries are keyed by register number, so a later hoisted load to the same register takes over that register's entry. When every entry is valid and a new register arrives, a round-robin pointer picks the entry to replace. The replaced register then reads as missing. Recovery code and the load datapath itself lie outside this block.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset no entry is valid: `chk_done` is low and every check reports a miss.
- R2: A check request on `chk_valid`/`chk_reg` is answered exactly one cycle later, with `chk_done` high for one cycle. `chk_hit` is high when a valid entry holds that register.
- R3: A check for a register that was never inserted reports a miss.
- R4: A store invalidates an entry when the two addresses agree in every bit above bit `OFFSET_W`-1 (the same 8-byte word by default). A store to any other word leaves the entry valid.
- R5: A single store invalidates every matching entry in the same cycle.
- R6: An insert for a register that already has a valid entry rewrites that entry and takes no other one. After that, only the new address is tracked for that register.
- R7: An insert for a new register goes to the lowest-numbered invalid entry. When all entries are valid, it replaces the entry at a round-robin pointer instead. The pointer starts at entry 0 after reset and advances by one, modulo `ENTRIES`, only on such a replacement. The replaced register then checks as a miss.
- R8: When an insert and a store to the same word arrive in the same cycle, the new entry is left valid.
- R9: A check sees the table as it stood before the updates of its own cycle. A check in the same cycle as the insert of its register misses. A check in the same cycle as a store that kills its register still hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Hoisted load records an entry this cycle |
| ins_reg | input | REG_W | Destination register of the hoisted load |
| ins_addr | input | ADDR_W | Byte address of the hoisted load |
| st_valid | input | 1 | Store address present this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check request this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_done | output | 1 | Check response valid (one cycle after request) |
| chk_hit | output | 1 | 1: speculative value safe; 0: branch to recovery |

## Verification
The hardest state to reach from the ports is a full table that still receives new registers. In that state the round-robin pointer chooses the victim, and the pointer has been moved by earlier evictions and not by inserts into free entries. The directed phase fills all four entries and then adds fresh registers. A long pseudo-random sweep follows, using only 8 registers and 8 address words. In that sweep, evictions, same-register rewrites, store kills and same-cycle collisions all recur many times, and a bench model that keeps its own pointer predicts every answer.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [1:0] {
    SRC_SAME  = 2'd0,
    SRC_FREE  = 2'd1,
    SRC_EVICT = 2'd2
  } slot_src_e;
endpackage

// File: rtl/slt_entry.sv
module slt_entry #(
  parameter int REG_W    = 7,
  parameter int ADDR_W   = 64,
  parameter int OFFSET_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              valid_o,
  output logic              same_ins_o,
  output logic              hit_chk_o,
  output logic              st_kill_o
);
  logic              valid_q;
  logic [REG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_q;

  function automatic logic same_word(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b);
    return ((a ^ b) >> OFFSET_W) == '0;
  endfunction

  assign st_kill_o  = valid_q && st_valid && same_word(addr_q, st_addr);
  assign same_ins_o = valid_q && (tag_q == wr_reg);
  assign hit_chk_o  = valid_q && (tag_q == chk_reg);
  assign valid_o    = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      addr_q  <= '0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      tag_q   <= wr_reg;
      addr_q  <= wr_addr;
    end else if (st_kill_o) begin
      valid_q <= 1'b0;
    end
  end

  // R4: a matching store with no write to this entry leaves it invalid
  assert_store_kills_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_kill_o && !wr_en) |=> !valid_q);
  // R8: a write always leaves the entry valid, even beside a colliding store
  assert_insert_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q && tag_q == $past(wr_reg)));
endmodule

// File: rtl/slt_victim.sv
module slt_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ins_valid,
  input  logic [ENTRIES-1:0] same_vec,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   slot_o,
  output logic               evict_o
);
  import slt_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_same;
  logic             any_free;
  slot_src_e        src;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    any_same = 1'b0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (same_vec[i]) begin
        same_idx = IDX_W'(i);
        any_same = 1'b1;
      end
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_same)      src = SRC_SAME;
    else if (any_free) src = SRC_FREE;
    else               src = SRC_EVICT;
  end

  always_comb begin
    case (src)
      SRC_SAME: slot_o = same_idx;
      SRC_FREE: slot_o = free_idx;
      default:  slot_o = ptr_q;
    endcase
  end

  assign evict_o = ins_valid && (src == SRC_EVICT);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (evict_o) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  // R6: at most one valid entry holds any register
  assert_same_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(same_vec));
  // R7: the pointer moves only on a replacement, and moves when one happens
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_o |=> $stable(ptr_q));
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_o |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
  parameter int ENTRIES  = 8,
  parameter int REG_W    = 7,
  parameter int ADDR_W   = 64,
  parameter int OFFSET_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [REG_W-1:0]  ins_reg,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              chk_done,
  output logic              chk_hit
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] same_vec;
  logic [ENTRIES-1:0] chk_vec;
  logic [ENTRIES-1:0] kill_vec;
  logic [IDX_W-1:0]   slot;
  logic               evict;
  logic               done_q;
  logic               hit_q;

  slt_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .same_vec  (same_vec),
    .valid_vec (valid_vec),
    .slot_o    (slot),
    .evict_o   (evict)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic wr_en;
    assign wr_en = ins_valid && (slot == IDX_W'(g));
    slt_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_reg     (ins_reg),
      .wr_addr    (ins_addr),
      .st_valid   (st_valid),
      .st_addr    (st_addr),
      .chk_reg    (chk_reg),
      .valid_o    (valid_vec[g]),
      .same_ins_o (same_vec[g]),
      .hit_chk_o  (chk_vec[g]),
      .st_kill_o  (kill_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      done_q <= chk_valid;
      hit_q  <= chk_valid && (|chk_vec);
    end
  end

  assign chk_done = done_q;
  assign chk_hit  = hit_q;

  // R2: every request is answered on the following cycle
  assert_resp_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);
  // R2: no response without a request
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_done);
  // R6: a lookup never finds the register in two entries
  assert_chk_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_vec));
  // R7: a replacement only happens when every entry is valid
  assert_evict_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evict |-> (&valid_vec));
  // R5: killed entries are gone next cycle unless rewritten
  assert_kill_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill_vec && !ins_valid) |=> ($countones(valid_vec) == $countones($past(valid_vec)) - $countones($past(kill_vec))));
endmodule

// File: tb/spec_load_tracker_bench.sv
`timescale 1ns/1ps
module spec_load_tracker_bench;
  localparam int E   = 4;
  localparam int RW  = 3;
  localparam int AW  = 16;
  localparam int OFF = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic [RW-1:0] ins_reg = '0;
  logic [AW-1:0] ins_addr = '0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic          chk_valid = 1'b0;
  logic [RW-1:0] chk_reg = '0;
  logic          chk_done;
  logic          chk_hit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit m_v [E];
  int m_r [E];
  int m_a [E];
  int m_ptr;

  always #2.5 clk = ~clk;

  spec_load_tracker #(.ENTRIES(E), .REG_W(RW), .ADDR_W(AW), .OFFSET_W(OFF)) u_spec_load_tracker (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_reg(ins_reg),
    .ins_addr(ins_addr), .st_valid(st_valid), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_done(chk_done), .chk_hit(chk_hit)
  );

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_hit(input int r);
    bit h = 0;
    for (int e = 0; e < E; e++) if (m_v[e] && m_r[e] == r) h = 1;
    return h;
  endfunction

  // One cycle: drive, predict from the pre-edge model, update model, sample after the edge.
  task automatic step(input bit iv, input int ir, input int ia,
                      input bit sv, input int sa,
                      input bit cv, input int cr, input string tag);
    bit exp_hit;
    int slot;
    exp_hit = model_hit(cr);
    slot = -1;
    for (int e = 0; e < E; e++) if (m_v[e] && m_r[e] == ir) slot = e;
    if (slot < 0) for (int e = E - 1; e >= 0; e--) if (!m_v[e]) slot = e;
    if (slot < 0 && iv) begin
      slot = m_ptr;
      m_ptr = (m_ptr + 1) % E;
    end
    if (sv) for (int e = 0; e < E; e++)
      if (m_v[e] && ((m_a[e] >> OFF) == (sa >> OFF))) m_v[e] = 0;
    if (iv) begin
      m_v[slot] = 1;
      m_r[slot] = ir;
      m_a[slot] = ia;
    end
    ins_valid = iv; ins_reg = RW'(ir); ins_addr = AW'(ia);
    st_valid = sv;  st_addr = AW'(sa);
    chk_valid = cv; chk_reg = RW'(cr);
    @(posedge clk);
    #1;
    ins_valid = 0; st_valid = 0; chk_valid = 0;
    expect_bit({tag, " done"}, chk_done, cv);
    if (cv) expect_bit({tag, " hit"}, chk_hit, exp_hit);
  endtask

  task automatic chk(input int r, input string tag);
    step(0, 0, 0, 0, 0, 1, r, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int e = 0; e < E; e++) begin m_v[e] = 0; m_r[e] = 0; m_a[e] = 0; end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    #1;
    expect_bit("R1 reset done", chk_done, 1'b0);
    rst_n = 1;
    for (int r = 0; r < 8; r++) chk(r, "R1");

    step(1, 1, 'h100, 0, 0, 0, 0, "R2 ins");
    chk(1, "R2");
    step(1, 2, 'h200, 0, 0, 1, 2, "R9 same-cycle ins");
    chk(2, "R9");
    chk(5, "R3");
    step(0, 0, 0, 1, 'h107, 0, 0, "R4 st");
    chk(1, "R4 same word");
    step(0, 0, 0, 1, 'h208, 0, 0, "R4 st other");
    chk(2, "R4 other word");
    step(0, 0, 0, 1, 'h200, 1, 2, "R9 same-cycle st");
    chk(2, "R9 after st");
    step(1, 3, 'h300, 0, 0, 0, 0, "R5 ins a");
    step(1, 4, 'h304, 0, 0, 0, 0, "R5 ins b");
    step(0, 0, 0, 1, 'h301, 0, 0, "R5 st");
    chk(3, "R5 a");
    chk(4, "R5 b");
    step(1, 5, 'h400, 0, 0, 0, 0, "R6 ins old");
    step(1, 5, 'h500, 0, 0, 0, 0, "R6 ins new");
    step(0, 0, 0, 1, 'h400, 0, 0, "R6 st old");
    chk(5, "R6 old addr");
    step(0, 0, 0, 1, 'h500, 0, 0, "R6 st new");
    chk(5, "R6 new addr");
    step(1, 6, 'h600, 1, 'h600, 0, 0, "R8 collide");
    chk(6, "R8");
    for (int r = 0; r < 4; r++) step(1, r, 'h1000 + 16 * r, 0, 0, 0, 0, "R7 fill");
    for (int r = 4; r < 8; r++) begin
      step(1, r, 'h2000 + 16 * r, 0, 0, 0, 0, "R7 evict");
      for (int q = 0; q < 8; q++) chk(q, "R7");
    end

    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      bit iv, sv, cv;
      int ir, ia, sa, cr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      iv = lfsr[0]; sv = lfsr[1] & lfsr[5]; cv = lfsr[2] | lfsr[6];
      ir = int'(lfsr[9:7]); cr = int'(lfsr[12:10]);
      ia = int'({lfsr[15:13], lfsr[4:3]}) << 1;
      sa = int'({lfsr[8:6], lfsr[11]}) << 2;
      step(iv, ir, ia, sv, sa, cv, cr, "R2 sweep");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule